// File: doc/BRIEF.md
# Data-Strobe Pair Receiver

This block takes a two-wire data-strobe serial link and rebuilds the bit stream from it. On every bit exactly one of the two wires changes level, so the exclusive-OR of the wires flips once per bit. The block uses that XOR as its recovered bit clock. The data wire is sampled at each rising and each falling event of this clock. Two consecutive bits form a pair. The earlier bit of a pair is the high bit.

Pairs are written into a small asynchronous FIFO in the recovered domain. The FIFO pointers are Gray-coded. The local link clock drains the FIFO and presents each pair as a 2-bit word with a valid flag. In full-speed mode a pair takes one link cycle. In half-speed mode the link runs at half the rate, so every pair is held for two local clocks.

A small alignment state machine in the local domain watches for the line going quiet. When the line stays quiet with an unpaired bit pending, the machine inverts the recovered clock back to its rest level. That inversion pushes the orphan bit into the FIFO as a marked entry, and the reader then discards that entry. The states are:

- **ACTIVE**: the line is in use and the quiet counter runs.
- **QUIET**: the line is aligned and resting.
- **DROP**: the reader is waiting to discard the entry that holds the orphan bit.

The transitions are:

- ACTIVE goes to QUIET when the time-out expires with the recovered clock at rest.
- ACTIVE goes to DROP when the time-out expires with the recovered clock raised. On this transition the polarity flip toggles.
- DROP goes to QUIET once the orphan entry has been discarded.
- QUIET goes to ACTIVE on any new FIFO write or any change of the recovered clock level.

Top module: `ds_pair_receiver`

## Requirements
- R1: While reset is asserted and on the first clock after it, `pair_valid` is 0 and `pair_data` is 2'b00.
- R2: The recovered bit clock is `ds_data ^ ds_strobe` (with the internal polarity flip), and `ds_data` is sampled at every event of it. The first bit after reset, or after an alignment reset, lands in `pair_data[1]` and the next one in `pair_data[0]`.
- R3: Every complete pair reaches the link side exactly once and in arrival order. This holds whenever the line's pair rate does not exceed the link pair rate. The FIFO write pointer seen by the reader moves by at most one Gray bit per local clock, and occupancy never exceeds the FIFO depth.
- R4: After TIMEOUT_CYCLES local clocks with no line activity, an odd leftover bit is discarded and never shows up on `pair_data`. The next bit on the line becomes a high bit. The discard cycle itself produces no valid.
- R5: With `half_speed` = 0, each pair is presented for exactly one clock with `pair_valid` = 1. Pairs may be presented on consecutive clocks.
- R6: With `half_speed` = 1, each pair is presented for exactly two consecutive clocks with `pair_valid` = 1, and `pair_data` stays unchanged between them.
- R7: `pair_valid` is never raised unless the FIFO held a written pair on the cycle before. A quiet line, including a quiet line after an even bit count, produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_link | input | 1 | Local free-running link clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| half_speed | input | 1 | 1 selects half-rate link (each pair held two clocks) |
| ds_data | input | 1 | Serial data wire |
| ds_strobe | input | 1 | Serial strobe wire |
| pair_data | output | 2 | Recovered pair, bit 1 = earlier bit |
| pair_valid | output | 1 | A pair is presented on `pair_data` |

## Verification
The embedded properties check the following on every local clock:

- the synchronized Gray write pointer moves by at most one bit;
- FIFO occupancy stays within the depth;
- the polarity flip only toggles while the recovered clock sits raised;
- a discard cycle is followed by no valid;
- in half-speed mode each pair is held stable for its second clock;
- a valid only rises after the FIFO was non-empty.

Some properties only the bench scenarios can show. These are: that pairs are assembled with the correct high/low order, that they arrive complete and in order under a frequency offset between line and link, and that orphan bits are really discarded rather than merged into the next burst. The bench shows these by comparing against a behavioural model of the bit stream it drives.

// File: rtl/ds_rx_pkg.sv
`timescale 1ns/1ps
package ds_rx_pkg;

    typedef enum logic [1:0] {
        ALN_ACTIVE = 2'd0,
        ALN_QUIET  = 2'd1,
        ALN_DROP   = 2'd2
    } align_state_e;

    typedef logic [1:0] bit_pair_t;

endpackage

// File: rtl/ds_rx_sync.sv
`timescale 1ns/1ps
module ds_rx_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q[0] <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ds_rx_capture.sv
`timescale 1ns/1ps
module ds_rx_capture
    import ds_rx_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                          rst_n,
    input  logic                          rec_clk,
    input  logic                          line_data,
    output logic [ADDR_W:0]               wr_gray,
    output bit_pair_t [(1<<ADDR_W)-1:0]   fifo_mem
);

    localparam int PTR_W = ADDR_W + 1;

    logic             hi_bit_q;
    logic [PTR_W-1:0] wr_bin_q;
    logic [PTR_W-1:0] wr_bin_nx;

    assign wr_bin_nx = wr_bin_q + PTR_W'(1);

    // First bit of a pair: rising event of the recovered clock.
    always_ff @(posedge rec_clk or negedge rst_n) begin
        if (!rst_n) hi_bit_q <= 1'b0;
        else        hi_bit_q <= line_data;
    end

    // Second bit of a pair: falling event; the pair is committed here.
    always_ff @(negedge rec_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin_q <= '0;
            wr_gray  <= '0;
            fifo_mem <= '0;
        end else begin
            fifo_mem[wr_bin_q[ADDR_W-1:0]] <= {hi_bit_q, line_data};
            wr_bin_q <= wr_bin_nx;
            wr_gray  <= wr_bin_nx ^ (wr_bin_nx >> 1);
        end
    end

endmodule

// File: rtl/ds_rx_reader.sv
`timescale 1ns/1ps
module ds_rx_reader
    import ds_rx_pkg::*;
#(
    parameter int ADDR_W         = 3,
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          half_speed,
    input  logic [ADDR_W:0]               wr_gray_s,
    input  logic                          rec_lvl_s,
    input  bit_pair_t [(1<<ADDR_W)-1:0]   fifo_mem,
    output bit_pair_t                     pair_data,
    output logic                          pair_valid,
    output logic                          clk_flip
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

    align_state_e state_q, state_nx;

    logic [PTR_W-1:0] wr_bin_s;
    logic [PTR_W-1:0] rd_bin_q;
    logic [PTR_W-1:0] wr_last_q;
    logic [PTR_W-1:0] skip_idx_q;
    logic             lvl_last_q;
    logic [CNT_W-1:0] quiet_cnt_q;
    logic             link_phase_q;

    logic slot_ok, fifo_has, at_skip, skip_now, pop, activity, timeout_hit;

    // Gray to binary conversion of the synchronized write pointer.
    always_comb begin
        wr_bin_s[PTR_W-1] = wr_gray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
        end
    end

    assign slot_ok     = !half_speed || !link_phase_q;
    assign fifo_has    = (wr_bin_s != rd_bin_q);
    assign at_skip     = (state_q == ALN_DROP) && (rd_bin_q == skip_idx_q);
    assign skip_now    = at_skip && fifo_has && slot_ok;
    assign pop         = fifo_has && !at_skip && slot_ok;
    assign activity    = (wr_bin_s != wr_last_q) || (rec_lvl_s != lvl_last_q);
    assign timeout_hit = (quiet_cnt_q == CNT_W'(TIMEOUT_CYCLES - 1)) && !activity;

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ALN_ACTIVE: if (timeout_hit) state_nx = rec_lvl_s ? ALN_DROP : ALN_QUIET;
            ALN_QUIET:  if (activity)    state_nx = ALN_ACTIVE;
            ALN_DROP:   if (skip_now)    state_nx = ALN_QUIET;
            default:                     state_nx = ALN_ACTIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALN_ACTIVE;
        else        state_q <= state_nx;
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin_q     <= '0;
            wr_last_q    <= '0;
            skip_idx_q   <= '0;
            lvl_last_q   <= 1'b0;
            quiet_cnt_q  <= '0;
            link_phase_q <= 1'b0;
            clk_flip     <= 1'b0;
            pair_data    <= '0;
            pair_valid   <= 1'b0;
        end else begin
            wr_last_q    <= wr_bin_s;
            lvl_last_q   <= rec_lvl_s;
            link_phase_q <= half_speed ? !link_phase_q : 1'b0;

            if (state_q == ALN_ACTIVE && !activity && !timeout_hit)
                quiet_cnt_q <= quiet_cnt_q + CNT_W'(1);
            else
                quiet_cnt_q <= '0;

            if (state_q == ALN_ACTIVE && timeout_hit && rec_lvl_s) begin
                clk_flip   <= !clk_flip;
                skip_idx_q <= wr_bin_s;
            end

            if (pop || skip_now) rd_bin_q <= rd_bin_q + PTR_W'(1);

            if (slot_ok) begin
                pair_valid <= pop;
                if (pop) pair_data <= fifo_mem[rd_bin_q[ADDR_W-1:0]];
            end
        end
    end

    // R3: the synchronized Gray pointer steps by at most one bit per clock
    a_r3_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_gray_s ^ $past(wr_gray_s)) <= 1);

    // R3: occupancy bounded by the depth
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(wr_bin_s - rd_bin_q)) <= PTR_W'(DEPTH));

    // R4: the polarity flip only toggles while the recovered clock is raised
    a_r4_flip_when_odd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_flip) |-> $past(rec_lvl_s));

    // R4: a discard cycle produces no valid
    a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        skip_now |=> !pair_valid);

    // R6: in half-speed mode a freshly raised pair is held one more clock
    a_r6_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        half_speed && $past(half_speed) && $rose(pair_valid) |=> pair_valid && $stable(pair_data));

    // R7: valid only rises after the FIFO held a pair
    a_r7_valid_from_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_valid) |-> $past(wr_bin_s != rd_bin_q));

endmodule

// File: rtl/ds_pair_receiver.sv
`timescale 1ns/1ps
module ds_pair_receiver
    import ds_rx_pkg::*;
#(
    parameter int FIFO_ADDR_W    = 3,
    parameter int TIMEOUT_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk_link,
    input  logic       rst_n,
    input  logic       half_speed,
    input  logic       ds_data,
    input  logic       ds_strobe,
    output logic [1:0] pair_data,
    output logic       pair_valid
);

    localparam int PTR_W = FIFO_ADDR_W + 1;
    localparam int DEPTH = 1 << FIFO_ADDR_W;

    logic                  clk_flip;
    logic                  rec_clk;
    logic [PTR_W-1:0]      wr_gray;
    logic [PTR_W-1:0]      wr_gray_s;
    logic                  rec_lvl_s;
    bit_pair_t [DEPTH-1:0] fifo_mem;
    bit_pair_t             pair_q;

    // Recovered bit clock: one level change per received bit.
    assign rec_clk = ds_data ^ ds_strobe ^ clk_flip;

    ds_rx_capture #(.ADDR_W(FIFO_ADDR_W)) i_capture (
        .rst_n     (rst_n),
        .rec_clk   (rec_clk),
        .line_data (ds_data),
        .wr_gray   (wr_gray),
        .fifo_mem  (fifo_mem)
    );

    ds_rx_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) i_ptr_sync (
        .clk     (clk_link),
        .rst_n   (rst_n),
        .d_async (wr_gray),
        .d_sync  (wr_gray_s)
    );

    ds_rx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_lvl_sync (
        .clk     (clk_link),
        .rst_n   (rst_n),
        .d_async (rec_clk),
        .d_sync  (rec_lvl_s)
    );

    ds_rx_reader #(.ADDR_W(FIFO_ADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_reader (
        .clk        (clk_link),
        .rst_n      (rst_n),
        .half_speed (half_speed),
        .wr_gray_s  (wr_gray_s),
        .rec_lvl_s  (rec_lvl_s),
        .fifo_mem   (fifo_mem),
        .pair_data  (pair_q),
        .pair_valid (pair_valid),
        .clk_flip   (clk_flip)
    );

    assign pair_data = pair_q;

endmodule

// File: tb/test_ds_pair_receiver.sv
`timescale 1ns/1ps
module test_ds_pair_receiver;

    logic       clk_link = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_speed = 1'b0;
    logic       ds_data = 1'b0;
    logic       ds_strobe = 1'b0;
    logic [1:0] pair_data;
    logic       pair_valid;

    int n_tests = 0;
    int n_fail  = 0;

    logic [1:0] exp_q[$];
    bit         have_hi = 0;
    bit         hi_val  = 0;
    realtime    bit_ns  = 10.3;
    bit         run_mon = 0;
    int         run_len = 0;
    logic [1:0] last_pair = 2'b00;
    bit         saw_b2b = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk_link = ~clk_link;   // 50 MHz

    ds_pair_receiver i_ds_pair_receiver (
        .clk_link   (clk_link),
        .rst_n      (rst_n),
        .half_speed (half_speed),
        .ds_data    (ds_data),
        .ds_strobe  (ds_strobe),
        .pair_data  (pair_data),
        .pair_valid (pair_valid)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one bit with data-strobe coding and update the reference model.
    task automatic send_bit(input bit b);
        if (b != ds_data) ds_data = b;
        else              ds_strobe = ~ds_strobe;
        if (!have_hi) begin
            hi_val  = b;
            have_hi = 1;
        end else begin
            exp_q.push_back({hi_val, b});
            have_hi = 0;
        end
        #(bit_ns);
    endtask

    task automatic send_rand(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0]);
        end
    endtask

    task automatic send_const(input int n, input bit v);
        for (int i = 0; i < n; i++) send_bit(v);
    endtask

    task automatic send_alt(input int n);
        for (int i = 0; i < n; i++) send_bit(i[0]);
    endtask

    // Quiet line long enough for the time-out: an orphan bit is dropped (R4).
    task automatic go_quiet;
        repeat (50) @(posedge clk_link);
        have_hi = 0;
    endtask

    // Cycle-by-cycle comparison against the model queue.
    always @(negedge clk_link) begin
        if (run_mon) begin
            if (pair_valid) begin
                run_len++;
                if (!half_speed || (run_len % 2 == 1)) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R7", "pair with nothing sent", int'(pair_data), -1);
                    end else begin
                        logic [1:0] e;
                        e = exp_q.pop_front();
                        chk(pair_data == e, "R2/R3", "pair value/order", int'(pair_data), int'(e));
                    end
                    if (!half_speed && run_len > 1) saw_b2b = 1;
                    last_pair = pair_data;
                end else begin
                    chk(pair_data == last_pair, "R6", "held pair changed", int'(pair_data), int'(last_pair));
                end
            end else begin
                if (half_speed && (run_len % 2 == 1))
                    chk(0, "R6", "valid run length", run_len, run_len + 1);
                run_len = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk_link);
        n_fail++;
        $display("FAIL R3 watchdog expired: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk_link);
        @(negedge clk_link);
        chk(pair_valid == 1'b0, "R1", "valid in reset", int'(pair_valid), 0);
        chk(pair_data == 2'b00, "R1", "data in reset", int'(pair_data), 0);
        rst_n = 1'b1;
        @(negedge clk_link);
        chk(pair_valid == 1'b0, "R1", "valid after reset", int'(pair_valid), 0);
        chk(pair_data == 2'b00, "R1", "data after reset", int'(pair_data), 0);
        run_mon = 1;
        repeat (5) @(posedge clk_link);

        // Full speed, line slightly slower than the link (R2, R3, R5).
        half_speed = 1'b0;
        bit_ns = 10.3;
        send_bit(1); send_bit(0);            // R2: expect 2'b10
        send_rand(60);
        go_quiet;
        send_const(10, 1'b1);
        send_alt(12);
        send_const(8, 1'b0);
        go_quiet;

        // Odd bursts with orphan bits (R4), then an isolated single bit.
        send_rand(7);
        go_quiet;
        send_rand(10);
        go_quiet;
        send_bit(1);
        go_quiet;
        send_bit(0); send_bit(1);            // R4: new high bit is 0
        go_quiet;

        // Half speed, line near the half link rate (R6).
        half_speed = 1'b1;
        bit_ns = 20.6;
        repeat (4) @(posedge clk_link);
        send_rand(40);
        go_quiet;
        send_rand(5);
        go_quiet;
        send_alt(8);
        go_quiet;

        // Back to full speed with a smaller offset.
        half_speed = 1'b0;
        bit_ns = 10.05;
        repeat (4) @(posedge clk_link);
        send_rand(80);
        send_bit(1);
        go_quiet;
        send_rand(20);
        go_quiet;

        chk(exp_q.size() == 0, "R3", "pairs never delivered", exp_q.size(), 0);
        chk(saw_b2b, "R5", "back-to-back full-speed pairs", int'(saw_b2b), 1);
        chk(pair_valid == 1'b0, "R7", "valid on quiet line", int'(pair_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule